// File: doc/BRIEF.md
# Root Port Status and Wake Controller

This block holds the live state of a single host-side root port and turns decoded line events into status updates, change flags, an interrupt request and a power-management wake request. The events are one-cycle pulses: resume K-state seen, device attached, device detached and over-current. The block accepts an event only when it makes sense for the current port state. An accepted event updates the live bits, raises the matching change flag and the global port-change flag, and can request a wake.

Software reads and writes three small registers through a simple synchronous port. With it, software enables or suspends the port, finishes a resume, clears change flags by writing ones, and sets the interrupt and per-event wake enables. A power-state input tells the block whether the controller sits in a low-power state. Wake requests are only produced while it does.

Top module: `usbp_root_status`

## Requirements
- R1: After reset every register reads zero, the port is detached, disabled and not suspended, and `irq`, `wake_req` and `resume_drive` are low.
- R2: A resume event while the port is not suspended changes no bit, requests no wake and leaves `resume_drive` low.
- R3: A resume event while the port is suspended sets the force-resume bit (PORT bit 3) and the port-change flag (STAT bit 0). It also pulses `resume_drive` high for exactly the cycle after the event.
- R4: An attach event while detached sets connected (PORT bit 0), connect-change (PORT bit 5) and the port-change flag. An attach event while connected has no effect.
- R5: A detach event while connected clears connected, enabled (bit 1), suspended (bit 2), force-resume and over-current-active (bit 4). It sets connect-change and the port-change flag. While detached the event has no effect.
- R6: An over-current event while connected sets over-current-active and over-current-change (PORT bit 6). It clears enabled, suspended and force-resume, and sets the port-change flag. While detached the event has no effect.
- R7: An accepted event pulses `wake_req` for exactly the cycle after it, but only while `low_power` is high. For attach, detach and over-current the matching CTRL enable must also be one (bit 1 attach, bit 2 detach, bit 3 over-current). An accepted resume always wakes. Status updates happen whether or not a wake is requested.
- R8: Whenever a wake is requested, the power-management status flag (STAT bit 1) is set.
- R9: `irq` is high exactly while the port-change flag and the interrupt enable (CTRL bit 0) are both one.
- R10: Writing one clears a flag: PORT bits 5 and 6 at address 0, STAT bits 0 and 1 at address 1. Live status bits are not touched. If an event sets a flag in the same cycle as a clear, the flag stays set.
- R11: When several events are accepted in one cycle, detach wins over over-current, and over-current wins over resume.
- R12: Address map: 0 PORT, 1 STAT, 2 CTRL (bits 3:0 read/write), 3 reads zero. A PORT write sets enabled from bit 1 only if connected. It sets suspended from bit 2 only together with enabled. It keeps force-resume only if bit 3 is one and the port stays suspended. Suspended always implies enabled, and enabled always implies connected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_resume | input | 1 | Resume K-state seen (pulse) |
| ev_connect | input | 1 | Device attach seen (pulse) |
| ev_disconnect | input | 1 | Device detach seen (pulse) |
| ev_overcur | input | 1 | Over-current seen (pulse) |
| low_power | input | 1 | Controller is in a low-power state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Power-management wake request |
| resume_drive | output | 1 | Drive resume downstream on this port |

## Verification
The checker watches every cycle for the effect of each accepted event one cycle later. It also checks that an ignored resume leaves state untouched, that wake only rises after a low-power cycle and always carries the power-management flag, and that the suspend-enable-connect nesting holds. What a property cannot cover is shown by the bench. It sweeps every starting port state against every event, both power states and every enable combination. It also runs the races between a clear and an event, simultaneous events, and the rules for writing the PORT register.

// File: rtl/usbp_pkg.sv
package usbp_pkg;

   // register addresses
   typedef enum logic [1:0] {
      RA_PORT  = 2'd0,
      RA_STAT  = 2'd1,
      RA_CTRL  = 2'd2,
      RA_SPARE = 2'd3
   } reg_addr_e;

   // PORT register bit positions
   localparam int unsigned PB_CONN  = 0;
   localparam int unsigned PB_EN    = 1;
   localparam int unsigned PB_SUSP  = 2;
   localparam int unsigned PB_FRES  = 3;
   localparam int unsigned PB_OCA   = 4;
   localparam int unsigned PB_CCHG  = 5;
   localparam int unsigned PB_OCCHG = 6;

   // STAT register bit positions
   localparam int unsigned SB_PCD = 0;
   localparam int unsigned SB_PM  = 1;

   // CTRL register bit positions
   localparam int unsigned CB_IRQ_EN  = 0;
   localparam int unsigned CB_WK_CONN = 1;
   localparam int unsigned CB_WK_DISC = 2;
   localparam int unsigned CB_WK_OC   = 3;
   localparam int unsigned CTRL_W     = 4;

   // flag array indices
   localparam int unsigned FI_CCHG  = 0;
   localparam int unsigned FI_OCCHG = 1;
   localparam int unsigned FI_PCD   = 2;
   localparam int unsigned FI_PM    = 3;
   localparam int unsigned FLAG_N   = 4;

   typedef struct packed {
      logic conn;
      logic en;
      logic susp;
      logic fres;
      logic oca;
   } port_st_t;

   typedef struct packed {
      logic disc;
      logic conn;
      logic oc;
      logic resume;
   } evt_t;

   typedef struct packed {
      logic wk_oc;
      logic wk_disc;
      logic wk_conn;
   } wake_en_t;

endpackage

// File: rtl/usbp_evt_qual.sv
module usbp_evt_qual
   import usbp_pkg::*;
(
   input  port_st_t st,
   input  logic     ev_resume,
   input  logic     ev_connect,
   input  logic     ev_disconnect,
   input  logic     ev_overcur,
   output evt_t     acc
);

   logic q_disc, q_conn, q_oc, q_res;

   // qualify each raw pulse against the current port state
   always_comb begin
      q_disc = ev_disconnect & st.conn;
      q_conn = ev_connect    & ~st.conn;
      q_oc   = ev_overcur    & st.conn;
      q_res  = ev_resume     & st.susp;
   end

   // attach is exclusive with the others; the rest follow a fixed priority
   always_comb begin
      acc.disc   = q_disc;
      acc.conn   = q_conn;
      acc.oc     = q_oc & ~q_disc;
      acc.resume = q_res & ~q_disc & ~q_oc;
   end

endmodule

// File: rtl/usbp_port_state.sv
module usbp_port_state
   import usbp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_we,
   input  logic [2:0] sw_bits,   // {fres, susp, en} as written
   input  evt_t       acc,
   output port_st_t   st
);

   port_st_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      // software request first
      if (sw_we) begin
         st_d.en   = sw_bits[0] & st_q.conn;
         st_d.susp = sw_bits[1] & st_d.en;
         st_d.fres = sw_bits[2] & st_q.fres & st_d.susp;
      end
      // accepted line events override software
      if (acc.conn) begin
         st_d.conn = 1'b1;
      end
      if (acc.oc) begin
         st_d.oca  = 1'b1;
         st_d.en   = 1'b0;
         st_d.susp = 1'b0;
         st_d.fres = 1'b0;
      end
      if (acc.resume) begin
         st_d.en   = 1'b1;
         st_d.susp = 1'b1;
         st_d.fres = 1'b1;
      end
      if (acc.disc) begin
         st_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   assign st = st_q;

endmodule

// File: rtl/usbp_w1c_flags.sv
module usbp_w1c_flags #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);

   generate
      if (N < 1) begin : g_bad_n
         $error("usbp_w1c_flags: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= set[i] | (f_q & ~clr[i]);
         end
         assign q[i] = f_q;
      end
   endgenerate

endmodule

// File: rtl/usbp_wake_ctl.sv
module usbp_wake_ctl
   import usbp_pkg::*;
#(
   parameter int unsigned WAKE_HOLD = 0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     low_power,
   input  evt_t     acc,
   input  wake_en_t wk_en,
   output logic     wake_fire,
   output logic     wake_req,
   output logic     resume_drive
);

   logic wake_q, rdrv_q;

   always_comb begin
      wake_fire = low_power & ((acc.conn & wk_en.wk_conn)
                             | (acc.disc & wk_en.wk_disc)
                             | (acc.oc   & wk_en.wk_oc)
                             |  acc.resume);
   end

   generate
      if (WAKE_HOLD == 0) begin : g_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wake_q <= 1'b0;
            else        wake_q <= wake_fire;
         end
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wake_q <= 1'b0;
            else        wake_q <= wake_fire | (wake_q & low_power);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdrv_q <= 1'b0;
      else        rdrv_q <= acc.resume;
   end

   assign wake_req     = wake_q;
   assign resume_drive = rdrv_q;

endmodule

// File: rtl/usbp_root_status.sv
module usbp_root_status
   import usbp_pkg::*;
#(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned WAKE_HOLD = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_resume,
   input  logic              ev_connect,
   input  logic              ev_disconnect,
   input  logic              ev_overcur,
   input  logic              low_power,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   output logic              wake_req,
   output logic              resume_drive
);

   localparam int unsigned MIN_DATA_W = PB_OCCHG + 1;

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_dw
         $error("usbp_root_status: DATA_W too narrow for PORT register");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("usbp_root_status: ADDR_W must be at least 2");
      end
      if (WAKE_HOLD > 1) begin : g_bad_wh
         $error("usbp_root_status: WAKE_HOLD must be 0 or 1");
      end
   endgenerate

   // address decode
   logic we_port, we_stat, we_ctrl;
   always_comb begin
      we_port = reg_wr & (reg_addr == ADDR_W'(RA_PORT));
      we_stat = reg_wr & (reg_addr == ADDR_W'(RA_STAT));
      we_ctrl = reg_wr & (reg_addr == ADDR_W'(RA_CTRL));
   end

   // control register
   logic [CTRL_W-1:0] ctrl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (we_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
   end

   wake_en_t wk_en;
   always_comb begin
      wk_en.wk_conn = ctrl_q[CB_WK_CONN];
      wk_en.wk_disc = ctrl_q[CB_WK_DISC];
      wk_en.wk_oc   = ctrl_q[CB_WK_OC];
   end

   // port state and event qualification
   port_st_t st_q;
   evt_t     acc;

   usbp_evt_qual u_qual (
      .st            (st_q),
      .ev_resume     (ev_resume),
      .ev_connect    (ev_connect),
      .ev_disconnect (ev_disconnect),
      .ev_overcur    (ev_overcur),
      .acc           (acc)
   );

   logic [2:0] sw_bits;
   assign sw_bits = {reg_wdata[PB_FRES], reg_wdata[PB_SUSP], reg_wdata[PB_EN]};

   usbp_port_state u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_we   (we_port),
      .sw_bits (sw_bits),
      .acc     (acc),
      .st      (st_q)
   );

   // wake and resume outputs
   logic wake_fire;

   usbp_wake_ctl #(.WAKE_HOLD(WAKE_HOLD)) u_wake (
      .clk          (clk),
      .rst_n        (rst_n),
      .low_power    (low_power),
      .acc          (acc),
      .wk_en        (wk_en),
      .wake_fire    (wake_fire),
      .wake_req     (wake_req),
      .resume_drive (resume_drive)
   );

   // change flags
   logic [FLAG_N-1:0] flg_set, flg_clr, flg_q;
   always_comb begin
      flg_set           = '0;
      flg_set[FI_CCHG]  = acc.conn | acc.disc;
      flg_set[FI_OCCHG] = acc.oc;
      flg_set[FI_PCD]   = acc.conn | acc.disc | acc.oc | acc.resume;
      flg_set[FI_PM]    = wake_fire;
      flg_clr           = '0;
      flg_clr[FI_CCHG]  = we_port & reg_wdata[PB_CCHG];
      flg_clr[FI_OCCHG] = we_port & reg_wdata[PB_OCCHG];
      flg_clr[FI_PCD]   = we_stat & reg_wdata[SB_PCD];
      flg_clr[FI_PM]    = we_stat & reg_wdata[SB_PM];
   end

   usbp_w1c_flags #(.N(FLAG_N)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flg_set),
      .clr   (flg_clr),
      .q     (flg_q)
   );

   // flat views used by the read mux and the bound checker
   logic p_conn, p_en, p_susp, p_fres, p_oca;
   logic f_cchg, f_occhg, f_pcd, f_pm, irq_en;
   always_comb begin
      p_conn  = st_q.conn;
      p_en    = st_q.en;
      p_susp  = st_q.susp;
      p_fres  = st_q.fres;
      p_oca   = st_q.oca;
      f_cchg  = flg_q[FI_CCHG];
      f_occhg = flg_q[FI_OCCHG];
      f_pcd   = flg_q[FI_PCD];
      f_pm    = flg_q[FI_PM];
      irq_en  = ctrl_q[CB_IRQ_EN];
   end

   assign irq = f_pcd & irq_en;

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(RA_PORT)) begin
         reg_rdata[PB_CONN]  = p_conn;
         reg_rdata[PB_EN]    = p_en;
         reg_rdata[PB_SUSP]  = p_susp;
         reg_rdata[PB_FRES]  = p_fres;
         reg_rdata[PB_OCA]   = p_oca;
         reg_rdata[PB_CCHG]  = f_cchg;
         reg_rdata[PB_OCCHG] = f_occhg;
      end else if (reg_addr == ADDR_W'(RA_STAT)) begin
         reg_rdata[SB_PCD] = f_pcd;
         reg_rdata[SB_PM]  = f_pm;
      end else if (reg_addr == ADDR_W'(RA_CTRL)) begin
         reg_rdata[CTRL_W-1:0] = ctrl_q;
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

endmodule

// File: rtl/usbp_root_status_chk.sv
module usbp_root_status_chk (
   input logic clk,
   input logic rst_n,
   input logic ev_resume,
   input logic ev_connect,
   input logic ev_disconnect,
   input logic ev_overcur,
   input logic low_power,
   input logic reg_wr,
   input logic irq,
   input logic wake_req,
   input logic resume_drive,
   input logic p_conn,
   input logic p_en,
   input logic p_susp,
   input logic p_fres,
   input logic p_oca,
   input logic f_cchg,
   input logic f_occhg,
   input logic f_pcd,
   input logic f_pm
);

   AST_RESUME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_resume && !p_susp && !ev_connect && !ev_disconnect && !ev_overcur && !reg_wr)
      |=> ($stable({p_conn, p_en, p_susp, p_fres, p_oca, f_pcd}) && !resume_drive)); // R2

   AST_RESUME_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_resume && p_susp && !ev_disconnect && !ev_overcur)
      |=> (p_fres && f_pcd && resume_drive)); // R3

   AST_ATTACH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_connect && !p_conn) |=> (p_conn && f_cchg && f_pcd)); // R4

   AST_DETACH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_disconnect && p_conn) |=> (!p_conn && !p_en && !p_susp && f_cchg && f_pcd)); // R5

   AST_OVERCUR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_overcur && p_conn && !ev_disconnect) |=> (p_oca && f_occhg && !p_en && f_pcd)); // R6

   AST_WAKE_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> $past(low_power)); // R7

   AST_WAKE_PMSTAT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> f_pm); // R8

   AST_IRQ_NEEDS_PCD: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> f_pcd); // R9

   AST_SUSP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      p_susp |-> p_en); // R12

   AST_EN_NEEDS_CONN: assert property (@(posedge clk) disable iff (!rst_n)
      p_en |-> p_conn); // R12

endmodule

bind usbp_root_status usbp_root_status_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ev_resume     (ev_resume),
   .ev_connect    (ev_connect),
   .ev_disconnect (ev_disconnect),
   .ev_overcur    (ev_overcur),
   .low_power     (low_power),
   .reg_wr        (reg_wr),
   .irq           (irq),
   .wake_req      (wake_req),
   .resume_drive  (resume_drive),
   .p_conn        (p_conn),
   .p_en          (p_en),
   .p_susp        (p_susp),
   .p_fres        (p_fres),
   .p_oca         (p_oca),
   .f_cchg        (f_cchg),
   .f_occhg       (f_occhg),
   .f_pcd         (f_pcd),
   .f_pm          (f_pm)
);

// File: tb/usbp_root_status_tb.sv
module usbp_root_status_tb;

   localparam int unsigned ADDR_W = 2;
   localparam int unsigned DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ev_resume = 1'b0, ev_connect = 1'b0, ev_disconnect = 1'b0, ev_overcur = 1'b0;
   logic              low_power = 1'b0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              irq, wake_req, resume_drive;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   usbp_root_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAKE_HOLD(0)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .ev_resume (ev_resume), .ev_connect (ev_connect),
      .ev_disconnect (ev_disconnect), .ev_overcur (ev_overcur),
      .low_power (low_power), .reg_wr (reg_wr), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .irq (irq), .wake_req (wake_req), .resume_drive (resume_drive)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      {ev_resume, ev_connect, ev_disconnect, ev_overcur, low_power, reg_wr} = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      reg_addr = ADDR_W'(a);
      #1;
      d = int'(reg_rdata);
   endtask

   // event vector e: bit0 resume, bit1 attach, bit2 detach, bit3 over-current
   task automatic pulse(input int e);
      ev_resume = e[0]; ev_connect = e[1]; ev_disconnect = e[2]; ev_overcur = e[3];
      @(negedge clk);
      {ev_resume, ev_connect, ev_disconnect, ev_overcur} = '0;
   endtask

   // bring the port to state s: 0 detached, 1 attached, 2 enabled, 3 suspended; flags cleared
   task automatic setup_state(input int s);
      int pb;
      if (s >= 1) pulse(2);
      pb = (s == 2) ? 2 : (s == 3) ? 6 : 0;
      wr(0, 8'h60 | pb);
      wr(1, 3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int v;
      do_reset();

      // R1 reset state
      rd(0, v); chk("R1", "PORT after reset", v, 0);
      rd(1, v); chk("R1", "STAT after reset", v, 0);
      rd(2, v); chk("R1", "CTRL after reset", v, 0);
      rd(3, v); chk("R12", "spare address", v, 0);
      chk("R1", "wake_req after reset", int'(wake_req), 0);
      chk("R1", "irq after reset", int'(irq), 0);
      chk("R1", "resume_drive after reset", int'(resume_drive), 0);

      // sweep: start state x power state x CTRL x event
      for (int s = 0; s < 4; s++) begin
         for (int lp = 0; lp < 2; lp++) begin
            for (int c = 0; c < 16; c++) begin
               for (int e = 0; e < 4; e++) begin
                  int conn0, en0, su0, acc;
                  int conn, en, su, fr, oca, cc, occ, pcd, wk, rdv, exp_port, exp_stat;
                  string tag;
                  do_reset();
                  wr(2, c);
                  setup_state(s);
                  low_power = lp[0];
                  @(negedge clk);
                  conn0 = (s >= 1); en0 = (s >= 2); su0 = (s == 3);
                  conn = conn0; en = en0; su = su0; fr = 0; oca = 0;
                  cc = 0; occ = 0; pcd = 0; wk = 0; rdv = 0;
                  case (e)
                     0: begin
                        acc = su0; tag = acc ? "R3" : "R2";
                        fr = acc; pcd = acc; rdv = acc; wk = lp & acc;
                     end
                     1: begin
                        acc = !conn0; tag = "R4";
                        if (acc) begin conn = 1; cc = 1; pcd = 1; end
                        wk = lp & acc & c[1];
                     end
                     2: begin
                        acc = conn0; tag = "R5";
                        if (acc) begin conn = 0; en = 0; su = 0; cc = 1; pcd = 1; end
                        wk = lp & acc & c[2];
                     end
                     default: begin
                        acc = conn0; tag = "R6";
                        if (acc) begin oca = 1; occ = 1; en = 0; su = 0; pcd = 1; end
                        wk = lp & acc & c[3];
                     end
                  endcase
                  exp_port = conn | (en << 1) | (su << 2) | (fr << 3) | (oca << 4) | (cc << 5) | (occ << 6);
                  exp_stat = pcd | (wk << 1);
                  pulse(1 << e);
                  chk("R7", "wake_req after event", int'(wake_req), wk);
                  chk(tag, "resume_drive after event", int'(resume_drive), rdv);
                  rd(0, v); chk(tag, "PORT after event", v, exp_port);
                  rd(1, v); chk("R8", "STAT after event", v, exp_stat);
                  chk("R9", "irq after event", int'(irq), pcd & c[0]);
                  @(negedge clk);
                  chk("R7", "wake_req one cycle later", int'(wake_req), 0);
                  chk("R3", "resume_drive one cycle later", int'(resume_drive), 0);
               end
            end
         end
      end

      // R10 clears leave live bits; event beats a same-cycle clear
      do_reset();
      wr(2, 1);
      pulse(2);
      chk("R9", "irq with flag and enable", int'(irq), 1);
      wr(0, 8'h20);
      rd(0, v); chk("R10", "clear connect-change keeps connected", v, 8'h01);
      rd(1, v); chk("R10", "port-change untouched by PORT clear", v, 1);
      wr(1, 1);
      rd(1, v); chk("R10", "port-change cleared", v, 0);
      chk("R9", "irq drops with flag", int'(irq), 0);
      do_reset();
      ev_connect = 1'b1; reg_addr = 0; reg_wdata = 8'h20; reg_wr = 1'b1;
      @(negedge clk);
      ev_connect = 1'b0; reg_wr = 1'b0;
      rd(0, v); chk("R10", "attach beats clear of connect-change", v, 8'h21);
      wr(1, 1);
      ev_disconnect = 1'b1; reg_addr = 1; reg_wdata = 8'h01; reg_wr = 1'b1;
      @(negedge clk);
      ev_disconnect = 1'b0; reg_wr = 1'b0;
      rd(1, v); chk("R10", "detach beats clear of port-change", v, 1);

      // R11 simultaneous events
      do_reset();
      setup_state(3);
      pulse(4'b0101);
      chk("R11", "no resume drive when detach wins", int'(resume_drive), 0);
      rd(0, v); chk("R11", "detach beats resume", v, 8'h20);
      do_reset();
      setup_state(3);
      pulse(4'b1001);
      chk("R11", "no resume drive when over-current wins", int'(resume_drive), 0);
      rd(0, v); chk("R11", "over-current beats resume", v, 8'h51);
      do_reset();
      pulse(4'b0110);
      rd(0, v); chk("R11", "attach taken when detach not qualified", v, 8'h21);

      // R12 PORT write rules
      do_reset();
      wr(0, 8'h06);
      rd(0, v); chk("R12", "enable refused while detached", v, 0);
      pulse(2);
      wr(0, 8'h24);
      rd(0, v); chk("R12", "suspend refused without enable", v, 8'h01);
      wr(0, 8'h06);
      rd(0, v); chk("R12", "enable and suspend", v, 8'h07);
      wr(1, 3);
      pulse(1);
      rd(0, v); chk("R3", "resume sets force-resume", v, 8'h0F);
      wr(0, 8'h0E);
      rd(0, v); chk("R12", "force-resume kept with bit 3 set", v, 8'h0F);
      wr(0, 8'h06);
      rd(0, v); chk("R12", "force-resume cleared by writing zero", v, 8'h07);
      wr(0, 8'h02);
      rd(0, v); chk("R12", "leave suspend", v, 8'h03);
      wr(2, 8'hFF);
      rd(2, v); chk("R12", "CTRL keeps only low bits", v, 8'h0F);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule